// File: doc/BRIEF.md
# PWM Action Qualifier with Software Force

This block turns time-base events into two PWM output levels. The time base supplies a tick enable and four event strobes: counter at zero, counter at period, compare-A match while counting up, and compare-B match while counting up. Each output has its own control word. That word gives every event a 2-bit action: leave the output alone, drive it low, drive it high, or toggle it. When several events arrive on the same tick, a fixed priority picks one action.

A continuous software force sits above the event logic and can hold either output low or high. Force writes land in a shadow register. A reload-mode field sets when the shadow is copied into the active force register: on a tick with a zero event, on a tick with a period event, on a tick with either event, or on the next tick of any kind. Configuration arrives through a plain write port with a 2-bit address. Ordinary duty-cycle setups follow from this. A normal-polarity channel sets high at zero and clears on its compare match. An inverted channel clears at zero and sets on its compare match.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset both outputs are low, both control words are zero, the force shadow and active fields are 00 (no force) and the reload mode is 00 (load on zero).
- R2: A write with cfg_addr 0 sets the output-A control word and a write with cfg_addr 1 sets the output-B control word. In each word, bits 1:0 hold the zero-event action, bits 3:2 the period-event action, bits 5:4 the compare-A action and bits 9:8 the compare-B action. Action codes are 00 none, 01 low, 10 high and 11 toggle.
- R3: Events act only when tb_tick is high. An output changes only on a clock edge where tb_tick is high, and it shows the result one clock after that edge.
- R4: When several events arrive on one tick, the winning action is taken from the highest-priority event whose action is not 00. The order from highest to lowest is compare-B, compare-A, period, zero.
- R5: A normal-polarity word (zero 10, compare 01) gives an output that is high from the zero tick up to the compare tick. An inverted word (zero 01, compare 10) gives the complement. If the compare action is 00, the output stays at its zero-event level for the whole period.
- R6: A write with cfg_addr 2 puts bits 1:0 (output A) and 3:2 (output B) into the force shadow, and puts bits 7:6 directly into the reload mode. Force codes are 01 force low and 10 force high; both 00 and 11 mean no force.
- R7: The shadow is copied into the active force on a tick with a zero event in mode 00, on a tick with a period event in mode 01, on a tick with either event in mode 10, and on any tick in mode 11. A newly loaded force takes effect on the same tick edge that loads it.
- R8: An active force of low or high sets the output on every tick and overrides all event actions. Once the force is released, the output keeps its last value until an event action changes it.
- R9: A write with cfg_addr 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | Time-base tick enable |
| evt_zero | input | 1 | Counter-at-zero strobe |
| evt_period | input | 1 | Counter-at-period strobe |
| evt_cmp_a | input | 1 | Compare-A up-count match strobe |
| evt_cmp_b | input | 1 | Compare-B up-count match strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Register select: 0 control A, 1 control B, 2 force, 3 unused |
| cfg_wdata | input | 16 | Write data |
| pwm_a | output | 1 | Output A level |
| pwm_b | output | 1 | Output B level |

## Verification
The bench builds the block with its default 16-bit configuration word. At that width the compare-B field at bits 9:8 and the reload-mode field at bits 7:6 are both reachable by the random writes. Directed sequences cover both polarities, the do-nothing compare, four-way event collisions, and each reload mode with its release behaviour. A long random run then mixes ticks, coincident events and writes to all four addresses. It is checked against a cycle model computed in the bench.

// File: rtl/aq_pkg.sv
package aq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } aq_act_e;

  typedef enum logic [1:0] {
    FRC_OFF  = 2'b00,
    FRC_LOW  = 2'b01,
    FRC_HIGH = 2'b10,
    FRC_NOP  = 2'b11
  } aq_frc_e;

  typedef enum logic [1:0] {
    RLD_ZERO = 2'b00,
    RLD_PRD  = 2'b01,
    RLD_EDGE = 2'b10,
    RLD_NOW  = 2'b11
  } aq_rld_e;

  typedef struct packed {
    logic zero;
    logic prd;
    logic cmpa;
    logic cmpb;
  } aq_evt_t;

  localparam int unsigned AQ_NCH       = 2;
  localparam int unsigned AQ_ADDR_W    = 2;
  localparam int unsigned FLD_ZERO     = 0;
  localparam int unsigned FLD_PRD      = 2;
  localparam int unsigned FLD_CMPA     = 4;
  localparam int unsigned FLD_CMPB     = 8;
  localparam int unsigned FLD_RLD      = 6;
  localparam logic [1:0]  ADDR_FORCE   = 2'd2;

endpackage

// File: rtl/aq_action_pick.sv
module aq_action_pick
  import aq_pkg::*;
#(
  parameter int unsigned CTL_W = 16
) (
  input  logic [CTL_W-1:0] ctl,
  input  aq_evt_t          ev,
  output aq_act_e          act
);
  localparam int unsigned MIN_W = FLD_CMPB + 2;

  aq_act_e f_zero, f_prd, f_cmpa, f_cmpb;

  assign f_zero = aq_act_e'(ctl[FLD_ZERO +: 2]);
  assign f_prd  = aq_act_e'(ctl[FLD_PRD  +: 2]);
  assign f_cmpa = aq_act_e'(ctl[FLD_CMPA +: 2]);
  assign f_cmpb = aq_act_e'(ctl[FLD_CMPB +: 2]);

  // later assignments win: lowest priority first
  always_comb begin
    act = ACT_NONE;
    if (ev.zero && f_zero != ACT_NONE) act = f_zero;
    if (ev.prd  && f_prd  != ACT_NONE) act = f_prd;
    if (ev.cmpa && f_cmpa != ACT_NONE) act = f_cmpa;
    if (ev.cmpb && f_cmpb != ACT_NONE) act = f_cmpb;
  end

  initial begin
    if (CTL_W < MIN_W) $error("CTL_W too small for the action fields");
  end
endmodule

// File: rtl/aq_force_ctrl.sv
module aq_force_ctrl
  import aq_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ev_zero,
  input  logic              ev_prd,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [2*NCH-1:0]  frc_shd,
  output logic [2*NCH-1:0]  frc_act,
  output logic [2*NCH-1:0]  frc_eff,
  output logic [1:0]        rld_mode
);
  localparam int unsigned FW = 2 * NCH;

  logic load;

  always_comb begin
    unique case (aq_rld_e'(rld_mode))
      RLD_ZERO: load = tick & ev_zero;
      RLD_PRD:  load = tick & ev_prd;
      RLD_EDGE: load = tick & (ev_zero | ev_prd);
      default:  load = tick;
    endcase
  end

  assign frc_eff = load ? frc_shd : frc_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_shd  <= '0;
      frc_act  <= '0;
      rld_mode <= RLD_ZERO;
    end else begin
      if (load) frc_act <= frc_shd;
      if (wr_en) begin
        frc_shd  <= wr_data[FW-1:0];
        rld_mode <= wr_data[FLD_RLD +: 2];
      end
    end
  end

  initial begin
    if (FW > FLD_RLD) $error("force fields overlap the reload mode field");
  end
endmodule

// File: rtl/aq_out_stage.sv
module aq_out_stage
  import aq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  aq_act_e    act,
  input  logic [1:0] frc,
  output logic       q
);
  logic q_next;

  always_comb begin
    q_next = q;
    unique case (aq_frc_e'(frc))
      FRC_LOW:  q_next = 1'b0;
      FRC_HIGH: q_next = 1'b1;
      default: begin
        unique case (act)
          ACT_LOW:    q_next = 1'b0;
          ACT_HIGH:   q_next = 1'b1;
          ACT_TOGGLE: q_next = ~q;
          default:    q_next = q;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (tick) q <= q_next;
  end
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import aq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_tick,
  input  logic              evt_zero,
  input  logic              evt_period,
  input  logic              evt_cmp_a,
  input  logic              evt_cmp_b,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              pwm_a,
  output logic              pwm_b
);
  localparam int unsigned NCH = AQ_NCH;

  aq_evt_t                      evt;
  logic [NCH-1:0][DATA_W-1:0]   ctl_word;
  logic [2*NCH-1:0]             frc_shd, frc_act, frc_eff;
  logic [1:0]                   rld_mode;
  logic [NCH-1:0]               pwm_q;

  assign evt = '{zero: evt_zero, prd: evt_period, cmpa: evt_cmp_a, cmpb: evt_cmp_b};

  aq_force_ctrl #(.NCH(NCH), .DATA_W(DATA_W)) u_force (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tb_tick),
    .ev_zero  (evt_zero),
    .ev_prd   (evt_period),
    .wr_en    (cfg_we && cfg_addr == ADDR_FORCE),
    .wr_data  (cfg_wdata),
    .frc_shd  (frc_shd),
    .frc_act  (frc_act),
    .frc_eff  (frc_eff),
    .rld_mode (rld_mode)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    aq_act_e act;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctl_word[ch] <= '0;
      else if (cfg_we && cfg_addr == AQ_ADDR_W'(ch))
        ctl_word[ch] <= cfg_wdata;
    end

    aq_action_pick #(.CTL_W(DATA_W)) u_pick (
      .ctl (ctl_word[ch]),
      .ev  (evt),
      .act (act)
    );

    aq_out_stage u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tb_tick),
      .act   (act),
      .frc   (frc_eff[2*ch +: 2]),
      .q     (pwm_q[ch])
    );
  end

  assign pwm_a = pwm_q[0];
  assign pwm_b = pwm_q[1];
endmodule

// File: rtl/pwm_action_qual_chk.sv
module pwm_action_qual_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tb_tick,
  input logic        evt_zero,
  input logic        evt_period,
  input logic        evt_cmp_a,
  input logic        evt_cmp_b,
  input logic        pwm_a,
  input logic        pwm_b,
  input logic [15:0] ctl_a,
  input logic [3:0]  frc_shd,
  input logic [3:0]  frc_act,
  input logic [3:0]  frc_eff,
  input logic [1:0]  rld_mode
);
  logic a_free;
  assign a_free = (frc_eff[1:0] != 2'b01) && (frc_eff[1:0] != 2'b10);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_tick |=> $stable(pwm_a) && $stable(pwm_b)); // R3

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_tick |=> $stable(frc_act)); // R7

  AST_NOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_tick && rld_mode == 2'b11) |=> frc_act == $past(frc_shd)); // R7

  AST_FORCE_HIGH_A: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_tick && frc_eff[1:0] == 2'b10) |=> pwm_a); // R8

  AST_FORCE_LOW_B: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_tick && frc_eff[3:2] == 2'b01) |=> !pwm_b); // R8

  AST_ZERO_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_tick && evt_zero && !evt_period && !evt_cmp_a && !evt_cmp_b &&
     ctl_a[1:0] == 2'b10 && a_free) |=> pwm_a); // R2

  AST_CMPB_WINS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_tick && evt_cmp_b && evt_cmp_a && ctl_a[9:8] == 2'b01 && a_free) |=> !pwm_a); // R4
endmodule

bind pwm_action_qual pwm_action_qual_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tb_tick    (tb_tick),
  .evt_zero   (evt_zero),
  .evt_period (evt_period),
  .evt_cmp_a  (evt_cmp_a),
  .evt_cmp_b  (evt_cmp_b),
  .pwm_a      (pwm_a),
  .pwm_b      (pwm_b),
  .ctl_a      (ctl_word[0][15:0]),
  .frc_shd    (frc_shd),
  .frc_act    (frc_act),
  .frc_eff    (frc_eff),
  .rld_mode   (rld_mode)
);

// File: tb/pwm_action_qual_test.sv
`timescale 1ns/1ps
module pwm_action_qual_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tb_tick = 1'b0;
  logic        evt_zero = 1'b0, evt_period = 1'b0, evt_cmp_a = 1'b0, evt_cmp_b = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        pwm_a, pwm_b;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  logic [15:0] m_ctl [2];
  logic [3:0]  m_shd, m_act;
  logic [1:0]  m_mode;
  logic [1:0]  m_q;

  always #10 clk = ~clk;

  pwm_action_qual uut (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick),
    .evt_zero(evt_zero), .evt_period(evt_period),
    .evt_cmp_a(evt_cmp_a), .evt_cmp_b(evt_cmp_b),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  function automatic logic [1:0] pick(input logic [15:0] c, input logic z, p, a, b);
    logic [1:0] r = 2'b00;
    if (b && c[9:8] != 2'b00) r = c[9:8];
    else if (a && c[5:4] != 2'b00) r = c[5:4];
    else if (p && c[3:2] != 2'b00) r = c[3:2];
    else if (z && c[1:0] != 2'b00) r = c[1:0];
    return r;
  endfunction

  function automatic logic next_level(input logic q, input logic [1:0] act, input logic [1:0] f);
    if (f == 2'b01) return 1'b0;
    if (f == 2'b10) return 1'b1;
    case (act)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~q;
      default: return q;
    endcase
  endfunction

  task automatic check(input string tag, input logic got, input logic exp, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(input logic t, z, p, a, b, we, input logic [1:0] ad,
                      input logic [15:0] d, input string tag);
    logic ld;
    logic [3:0] feff;
    @(negedge clk);
    tb_tick = t; evt_zero = z; evt_period = p; evt_cmp_a = a; evt_cmp_b = b;
    cfg_we = we; cfg_addr = ad; cfg_wdata = d;
    case (m_mode)
      2'b00:   ld = t & z;
      2'b01:   ld = t & p;
      2'b10:   ld = t & (z | p);
      default: ld = t;
    endcase
    feff = ld ? m_shd : m_act;
    if (t) begin
      for (int ch = 0; ch < 2; ch++)
        m_q[ch] = next_level(m_q[ch], pick(m_ctl[ch], z, p, a, b), feff[2*ch +: 2]);
    end
    if (ld) m_act = m_shd;
    if (we) begin
      if (ad == 2'd0) m_ctl[0] = d;
      if (ad == 2'd1) m_ctl[1] = d;
      if (ad == 2'd2) begin m_shd = d[3:0]; m_mode = d[7:6]; end
    end
    @(posedge clk);
    #2;
    check(tag, pwm_a, m_q[0], "pwm_a");
    check(tag, pwm_b, m_q[1], "pwm_b");
  endtask

  task automatic wr(input logic [1:0] ad, input logic [15:0] d, input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, ad, d, tag);
  endtask

  task automatic ev(input logic z, p, a, b, input string tag);
    step(1'b1, z, p, a, b, 1'b0, 2'd0, 16'd0, tag);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    m_ctl[0] = '0; m_ctl[1] = '0; m_shd = '0; m_act = '0; m_mode = '0; m_q = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", pwm_a, 1'b0, "pwm_a after reset");
    check("R1", pwm_b, 1'b0, "pwm_b after reset");
    @(negedge clk); rst_n = 1'b1;
    // R1: zero control words mean events do nothing
    ev(1, 1, 1, 1, "R1");

    // R5: A normal polarity (zero high, cmpA low), B inverted (zero low, cmpB high)
    wr(2'd0, 16'h0012, "R2");
    wr(2'd1, 16'h0201, "R2");
    for (int c = 0; c < 24; c++) begin
      int k = c % 8;
      ev(k == 0, k == 7, k == 3, k == 5, "R5");
    end
    // R5: compare action none keeps zero level
    wr(2'd0, 16'h0002, "R5");
    for (int c = 0; c < 16; c++) begin
      int k = c % 8;
      ev(k == 0, k == 7, k == 3, k == 5, "R5");
    end

    // R4: collisions
    wr(2'd0, 16'h0139, "R4");  // zero low, prd high, cmpA toggle, cmpB low
    ev(1, 1, 1, 1, "R4");
    ev(1, 1, 1, 0, "R4");
    ev(1, 1, 1, 0, "R4");
    ev(1, 1, 0, 0, "R4");
    ev(1, 0, 0, 0, "R4");
    // R3: events without tick do nothing
    step(0, 0, 1, 0, 0, 0, 2'd0, 16'd0, "R3");
    step(0, 0, 1, 1, 1, 0, 2'd0, 16'd0, "R3");

    // R7: immediate mode, A forced high on next tick
    wr(2'd2, 16'h00C2, "R7");
    ev(0, 0, 0, 0, "R7");
    ev(1, 0, 0, 0, "R8");      // zero-low action is overridden
    // R8: release in immediate mode, level holds until an event acts
    wr(2'd2, 16'h00C0, "R8");
    ev(0, 0, 0, 0, "R8");
    ev(0, 0, 1, 0, "R8");
    // R7: mode zero-load, B forced high only at a zero tick
    wr(2'd2, 16'h0008, "R7");
    ev(0, 1, 0, 0, "R7");
    ev(0, 0, 0, 0, "R7");
    ev(1, 0, 0, 0, "R7");
    ev(0, 0, 0, 1, "R7");
    // R7: period-load and either-edge modes
    wr(2'd2, 16'h0045, "R7");
    ev(1, 0, 0, 0, "R7");
    ev(0, 1, 0, 0, "R7");
    wr(2'd2, 16'h008A, "R7");
    ev(0, 0, 1, 0, "R7");
    ev(1, 0, 0, 0, "R7");
    // R6: code 11 means no force
    wr(2'd2, 16'h00CF, "R6");
    ev(0, 0, 0, 0, "R6");
    ev(1, 0, 0, 0, "R6");
    ev(0, 1, 0, 0, "R6");
    // R9: address 3 writes ignored
    wr(2'd3, 16'hFFFF, "R9");
    ev(1, 1, 0, 0, "R9");
    ev(0, 0, 0, 0, "R9");

    // random mix (R2, R4, R7)
    for (int i = 0; i < 4000; i++) begin
      logic t, z, p, a, b, we;
      logic [1:0] ad;
      logic [15:0] d;
      t  = ($urandom % 4) != 0;
      z  = ($urandom % 5) == 0;
      p  = ($urandom % 5) == 0;
      a  = ($urandom % 4) == 0;
      b  = ($urandom % 4) == 0;
      we = ($urandom % 8) == 0;
      ad = 2'($urandom);
      d  = 16'($urandom);
      step(t, z, p, a, b, we, ad, d, "R2");
    end

    step(0, 0, 0, 0, 0, 0, 2'd0, 16'd0, "R3");
    finish_run();
  end
endmodule